// File: doc/BRIEF.md
# Address Acknowledge Timing Generator

This block sits on the target or arbiter side of a split-transaction processor bus and closes the address phase. It samples a one-cycle transfer-start strobe and later drives a one-cycle address-acknowledge pulse. The pulse comes no earlier than a minimum slot, and that slot depends on the clock-ratio mode. A programmable extra wait can push the pulse later to give slow devices more address access time. A snoop-busy hold from slow snoopers can also postpone it.

After a strobe is accepted, a small down-counter is loaded with the total number of address wait states. The wait-state total is the extra wait plus one more state when the tight-ratio mode is selected. The acknowledge fires in the first cycle in which the count has run out and the snoop hold is low. While an address phase is waiting, any further strobe is flagged on a protocol-error output and is otherwise ignored.

Top module: `aack_gen`

## Requirements
- R1: With `tight_ratio` low and `extra_wait` zero, a strobe sampled high in cycle N with the block idle gives `addr_ack` high in cycle N+1, provided `snoop_hold` is low then.
- R2: With `tight_ratio` high, the wait-state total gains one, so the earliest acknowledge is cycle N+2. `addr_ack` is never high in cycle N+1.
- R3: `extra_wait` (0 to 15) adds that many wait states: the acknowledge comes no earlier than cycle N+1+`extra_wait`+(1 if `tight_ratio`). The mode and wait inputs matter only in the strobe cycle.
- R4: `addr_ack` stays low in every cycle where `snoop_hold` is high. It fires in the first cycle, at or after the earliest slot, in which `snoop_hold` is low. The wait count keeps running while the hold is high.
- R5: `addr_ack` is a single-cycle pulse, exactly one per accepted strobe, and is low in the cycle after it is high.
- R6: The block is busy from the cycle after an accepted strobe up to and including its acknowledge cycle. A strobe during that time raises `proto_err` in the same cycle. Such a strobe does not change the pending acknowledge's timing and produces no acknowledge of its own. An accepted strobe leaves `proto_err` low.
- R7: While `rst_n` is low, `addr_ack` and `proto_err` are low. Reset drops any pending acknowledge, so no acknowledge follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | Transfer-start strobe, one cycle |
| tight_ratio | input | 1 | High selects one of the two tight clock-ratio modes (one forced wait state) |
| extra_wait | input | WAIT_W | Extra address wait states, sampled with the strobe |
| snoop_hold | input | 1 | High while a snooper or device needs more time |
| addr_ack | output | 1 | Address-acknowledge pulse |
| proto_err | output | 1 | Strobe seen while an address phase is still pending |

## Verification
Transfers are driven with zero extra wait in both ratio modes to tell the one-cycle slot apart from the forced wait state. Non-zero extra waits (including the maximum, 15) show whether the wait is added on top of the mode minimum rather than replacing it. Snoop holds shorter than, equal to, and longer than the wait count separate "hold only postpones past expiry" from "hold stalls the counter". Overlapping strobes are placed both mid-wait and in the acknowledge cycle itself, and a reset is applied mid-wait; these show that the ignored strobes and the dropped phase leave no stray or shifted pulse.

// File: rtl/aack_gen.sv
module aack_gen #(
  parameter int WAIT_W   = 4,
  parameter int TIGHT_WS = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start,
  input  logic              tight_ratio,
  input  logic [WAIT_W-1:0] extra_wait,
  input  logic              snoop_hold,
  output logic              addr_ack,
  output logic              proto_err
);
  localparam int CNT_W = WAIT_W + 1;

  logic             busy;
  logic [CNT_W-1:0] cnt;

  wire              accept  = xfer_start && !busy;
  wire [CNT_W-1:0]  mode_ws = tight_ratio ? CNT_W'(TIGHT_WS) : '0;
  wire [CNT_W-1:0]  load_ws = CNT_W'(extra_wait) + mode_ws;

  assign addr_ack  = busy && (cnt == '0) && !snoop_hold;
  assign proto_err = xfer_start && busy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (accept) begin
      busy <= 1'b1;
      cnt  <= load_ws;
    end else if (addr_ack) begin
      busy <= 1'b0;
    end else if (busy && cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end
endmodule

module aack_gen_chk #(
  parameter int WAIT_W = 4,
  parameter int CNT_W  = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              xfer_start,
  input logic              tight_ratio,
  input logic [WAIT_W-1:0] extra_wait,
  input logic              snoop_hold,
  input logic              addr_ack,
  input logic              proto_err,
  input logic              busy,
  input logic [CNT_W-1:0]  cnt
);
  p_normal_slot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && !busy && !tight_ratio && extra_wait == '0) |=> (addr_ack || snoop_hold));

  p_tight_gap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && !busy && tight_ratio) |=> !addr_ack);

  p_extra_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer_start && !busy && extra_wait != '0) |=> !addr_ack);

  p_hold_blocks_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && snoop_hold) |=> busy);

  p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
    addr_ack |=> !addr_ack);

  p_err_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (proto_err && cnt != '0) |=> (busy && cnt == $past(cnt) - 1'b1));

  always @(posedge clk) begin
    if (!rst_n) begin
      p_reset_quiet_r7: assert (!addr_ack && !proto_err);
    end
  end
endmodule

bind aack_gen aack_gen_chk #(.WAIT_W(WAIT_W), .CNT_W(WAIT_W + 1)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .tight_ratio(tight_ratio),
  .extra_wait(extra_wait), .snoop_hold(snoop_hold), .addr_ack(addr_ack),
  .proto_err(proto_err), .busy(busy), .cnt(cnt)
);

// File: tb/aack_gen_tb.sv
`timescale 1ns/1ps
module aack_gen_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       xfer_start = 1'b0;
  logic       tight_ratio = 1'b0;
  logic [3:0] extra_wait = '0;
  logic       snoop_hold = 1'b0;
  logic       addr_ack;
  logic       proto_err;

  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;
  int    exp_q[$];
  string tag_q[$];
  bit    prev_ack = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  aack_gen u_dut (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .tight_ratio(tight_ratio),
    .extra_wait(extra_wait), .snoop_hold(snoop_hold), .addr_ack(addr_ack),
    .proto_err(proto_err)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d (cycle %0d)", tag, act, exp, cyc);
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  // monitor: pops expected acknowledge cycles and compares
  initial forever begin
    @(negedge clk); #2;
    if (!rst_n) begin
      prev_ack = 1'b0;
    end else begin
      if (addr_ack) begin
        chk(!prev_ack, "R5 pulse width", 2, 1);
        if (exp_q.size() == 0) begin
          chk(1'b0, "R6 unexpected acknowledge", cyc, -1);
        end else begin
          automatic int    e = exp_q.pop_front();
          automatic string t = tag_q.pop_front();
          chk(e == cyc, t, cyc, e);
        end
      end
      prev_ack = addr_ack;
    end
  end

  task automatic drain();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic txn(input bit t, input int ex, input int hold);
    int s, ws, e;
    string tag;
    @(negedge clk);
    xfer_start = 1'b1; tight_ratio = t; extra_wait = 4'(ex); snoop_hold = 1'b0;
    s  = cyc;
    ws = ex + (t ? 1 : 0);
    e  = (hold <= ws) ? s + 1 + ws : s + 1 + hold;
    tag = (hold > ws) ? "R4 hold" : (t ? "R2 tight" : (ex > 0 ? "R3 extra" : "R1 normal"));
    exp_q.push_back(e); tag_q.push_back(tag);
    #2 chk(proto_err == 1'b0, "R6 accepted strobe", proto_err, 0);
    @(negedge clk);
    xfer_start = 1'b0;
    tight_ratio = ~t; extra_wait = 4'd15;
    if (hold > 0) begin
      snoop_hold = 1'b1;
      repeat (hold) @(negedge clk);
      snoop_hold = 1'b0;
    end
    drain();
  endtask

  initial begin
    #2;
    chk(addr_ack == 1'b0, "R7 reset ack", addr_ack, 0);
    chk(proto_err == 1'b0, "R7 reset err", proto_err, 0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    txn(0, 0, 0);
    txn(1, 0, 0);
    txn(0, 3, 0);
    txn(1, 4, 0);
    txn(0, 15, 0);
    txn(1, 15, 0);
    txn(0, 0, 3);
    txn(1, 2, 3);
    txn(0, 5, 2);
    txn(0, 4, 4);
    txn(1, 0, 1);

    // R6: strobe mid-wait is flagged and ignored
    begin
      int s;
      @(negedge clk);
      xfer_start = 1'b1; tight_ratio = 1'b0; extra_wait = 4'd3;
      s = cyc;
      exp_q.push_back(s + 4); tag_q.push_back("R6 timing kept");
      @(negedge clk);
      extra_wait = 4'd0; tight_ratio = 1'b0;
      #2 chk(proto_err == 1'b1, "R6 mid-wait flag", proto_err, 1);
      @(negedge clk);
      xfer_start = 1'b0;
      drain();
      repeat (4) @(negedge clk);
    end

    // R6: strobe in the acknowledge cycle is flagged and ignored
    begin
      int s;
      @(negedge clk);
      xfer_start = 1'b1; tight_ratio = 1'b0; extra_wait = 4'd2;
      s = cyc;
      exp_q.push_back(s + 3); tag_q.push_back("R6 ack-cycle timing");
      @(negedge clk);
      xfer_start = 1'b0;
      repeat (2) @(negedge clk);
      xfer_start = 1'b1; extra_wait = 4'd0;
      #2 chk(proto_err == 1'b1 && addr_ack == 1'b1, "R6 ack-cycle flag", {proto_err, addr_ack}, 3);
      @(negedge clk);
      xfer_start = 1'b0;
      drain();
      repeat (4) @(negedge clk);
    end

    txn(0, 0, 0);

    // R7: reset mid-wait drops the pending acknowledge
    @(negedge clk);
    xfer_start = 1'b1; tight_ratio = 1'b0; extra_wait = 4'd10;
    @(negedge clk);
    xfer_start = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b0;
    #2 chk(addr_ack == 1'b0 && proto_err == 1'b0, "R7 reset mid-wait", {addr_ack, proto_err}, 0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (16) @(negedge clk);

    txn(1, 1, 0);
    txn(0, 0, 0);

    chk(exp_q.size() == 0, "R5 missing acknowledge", exp_q.size(), 0);
    summary();
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    summary();
  end
endmodule